// File: doc/BRIEF.md
# CPU Clock Mode Controller

This block decides which clock the CPU runs on and whether it runs at all. Two operating modes are supported. In SLOW mode the raw oscillator clock passes straight through as the system clock, giving 2 MHz. In NORMAL mode the system clock comes from a PLL that multiplies the oscillator by twelve and halves the result, giving 12 MHz. The PLL is outside this block and reaches it as a clock and a lock flag. Two standby modes are supported. HALT stops the CPU while the peripherals keep their clocks. STOP removes every clock.

Reset always leaves the block in SLOW mode. The only way into NORMAL mode is a software command. That command waits for the PLL lock flag and then changes source through a handshake, so that the system clock never carries a runt pulse. A standby mode is left on a wake request, and the block then returns to the operating mode that was active before standby. A second register holds one clock-enable bit per peripheral function. Bit 0 is the ADC, and reset clears it.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset `mode_status` is 00, `cpu_clk_en` is 1 and `periph_clk_en` equals 8'hFE, which means the ADC enable (bit 0) is clear and every other function is enabled.
- R2: While the mode is SLOW, `sys_clk` follows `osc_clk` and carries no `pll_clk` pulses.
- R3: A mode write (`wr_sel`=0) with `wr_data[1:0]`=01 issued in SLOW mode, with `pll_locked` high, brings `mode_status` to 01 within 40 oscillator cycles. From then on `sys_clk` follows `pll_clk`.
- R4: While `pll_locked` is low, a pending request for NORMAL mode does not switch the clock: `mode_status` stays 00 and `sys_clk` keeps following `osc_clk`. The switch proceeds once the lock flag rises.
- R5: Without a mode write of 01, the block never leaves SLOW for NORMAL, however long `pll_locked` stays high.
- R6: A mode write of 00 in NORMAL mode returns the block to SLOW: `mode_status` reads 00 and `sys_clk` follows `osc_clk` again within a few cycles.
- R7: A mode write of 10 in SLOW or NORMAL enters HALT. On the next cycle `mode_status` reads 10 and `cpu_clk_en` is 0, while `periph_clk_en` and `sys_clk` keep running.
- R8: A mode write of 11 in SLOW or NORMAL enters STOP. `mode_status` reads 11, `cpu_clk_en` and every `periph_clk_en` bit read 0, and `sys_clk` settles low until a wake request arrives.
- R9: A high `wake` in HALT or STOP returns the block to the operating mode that was active before entry, restoring `cpu_clk_en` and the peripheral enables. From STOP, NORMAL is shown again once the PLL clock drives `sys_clk`.
- R10: A write with `wr_sel`=1 loads `wr_data` into the peripheral enables. A 1 in a bit turns that function's clock on.
- R11: Mode writes issued in HALT or STOP are ignored, and so is a write of 01 in NORMAL mode.
- R12: The oscillator and PLL paths never drive `sys_clk` together, and `mode_status` reads 01 only once the PLL clock already drives `sys_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Raw oscillator clock. It also clocks the control logic. |
| pll_clk | input | 1 | PLL output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_locked | input | 1 | PLL lock flag, asynchronous to this block |
| wr_en | input | 1 | Register write strobe, one oscillator cycle long |
| wr_sel | input | 1 | 0 selects the mode command, 1 selects the peripheral enables |
| wr_data | input | NPERIPH | Write data. For a mode write, bits [1:0] hold 00 SLOW, 01 NORMAL, 10 HALT or 11 STOP. |
| wake | input | 1 | Wake request that ends HALT or STOP |
| cpu_clk_en | output | 1 | CPU clock enable, low in HALT and STOP |
| sys_clk | output | 1 | Selected, glitch-free system clock |
| mode_status | output | 2 | Current mode: 00 SLOW, 01 NORMAL, 10 HALT, 11 STOP |
| periph_clk_en | output | NPERIPH | Per-peripheral clock enables |

## Verification
The bench asks for NORMAL mode while the PLL is unlocked. A design that skipped the lock wait would jump straight to PLL and fail the SLOW-hold check. It also leaves the lock flag high with no command, which catches a design that moves to NORMAL on its own. STOP is entered from both operating modes and is followed by writes that must be ignored and then by a wake. A design that lost the return mode, or that left a source running or the peripherals enabled in STOP, would show the wrong status, pulses on `sys_clk` or nonzero enables. At the cycle the status turns to NORMAL, the bench confirms that `sys_clk` already tracks the PLL edges, which exposes a status that runs ahead of the clock handover.

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl #(
  parameter int NPERIPH = 8,
  parameter logic [NPERIPH-1:0] PERIPH_RST = {{(NPERIPH-1){1'b1}}, 1'b0}
) (
  input  logic               osc_clk,
  input  logic               pll_clk,
  input  logic               rst_n,
  input  logic               pll_locked,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [NPERIPH-1:0] wr_data,
  input  logic               wake,
  output logic               cpu_clk_en,
  output logic               sys_clk,
  output logic [1:0]         mode_status,
  output logic [NPERIPH-1:0] periph_clk_en
);

  localparam logic [1:0] C_SLOW = 2'b00, C_NORM = 2'b01, C_HALT = 2'b10, C_STOP = 2'b11;

  typedef enum logic [2:0] {S_SLOW, S_GO_PLL, S_NORMAL, S_GO_OSC, S_HALT, S_STOP} st_t;

  st_t st;
  logic sel_pll, stop_req, ret_norm;
  logic [NPERIPH-1:0] preg;
  logic [1:0] lock_s, pllon_s, pll_req;
  logic osc_req, osc_on, pll_on;

  wire       cmd_wr = wr_en && !wr_sel;
  wire [1:0] cmd    = wr_data[1:0];

  // oscillator side of the handover
  always_ff @(posedge osc_clk or negedge rst_n)
    if (!rst_n) osc_req <= 1'b1;
    else        osc_req <= !sel_pll && !pllon_s[1] && !stop_req;

  always_ff @(negedge osc_clk or negedge rst_n)
    if (!rst_n) osc_on <= 1'b1;
    else        osc_on <= osc_req;

  // PLL side of the handover
  always_ff @(posedge pll_clk or negedge rst_n)
    if (!rst_n) pll_req <= 2'b00;
    else        pll_req <= {pll_req[0], sel_pll && !osc_on && !stop_req};

  always_ff @(negedge pll_clk or negedge rst_n)
    if (!rst_n) pll_on <= 1'b0;
    else        pll_on <= pll_req[1];

  assign sys_clk = (osc_clk & osc_on) | (pll_clk & pll_on);

  always_ff @(posedge osc_clk or negedge rst_n)
    if (!rst_n) begin
      lock_s  <= 2'b00;
      pllon_s <= 2'b00;
    end else begin
      lock_s  <= {lock_s[0], pll_locked};
      pllon_s <= {pllon_s[0], pll_on};
    end

  // mode sequencer
  always_ff @(posedge osc_clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_SLOW;
      sel_pll  <= 1'b0;
      stop_req <= 1'b0;
      ret_norm <= 1'b0;
    end else begin
      case (st)
        S_SLOW:
          if (cmd_wr)
            case (cmd)
              C_NORM: st <= S_GO_PLL;
              C_HALT: begin st <= S_HALT; ret_norm <= 1'b0; end
              C_STOP: begin st <= S_STOP; ret_norm <= 1'b0; stop_req <= 1'b1; end
              default: ;
            endcase
        S_GO_PLL: begin
          if (!sel_pll && lock_s[1]) sel_pll <= 1'b1;
          if (sel_pll && pllon_s[1]) st <= S_NORMAL;
        end
        S_NORMAL:
          if (cmd_wr)
            case (cmd)
              C_SLOW: begin st <= S_GO_OSC; sel_pll <= 1'b0; end
              C_HALT: begin st <= S_HALT; ret_norm <= 1'b1; end
              C_STOP: begin st <= S_STOP; ret_norm <= 1'b1; stop_req <= 1'b1; end
              default: ;
            endcase
        S_GO_OSC:
          if (osc_on) st <= S_SLOW;
        S_HALT:
          if (wake) st <= ret_norm ? S_NORMAL : S_SLOW;
        S_STOP:
          if (wake) begin
            stop_req <= 1'b0;
            st       <= ret_norm ? S_GO_PLL : S_GO_OSC;
          end
        default: st <= S_SLOW;
      endcase
    end

  always_ff @(posedge osc_clk or negedge rst_n)
    if (!rst_n)                preg <= PERIPH_RST;
    else if (wr_en && wr_sel)  preg <= wr_data;

  assign cpu_clk_en    = !(st == S_HALT || st == S_STOP);
  assign periph_clk_en = stop_req ? '0 : preg;

  always_comb
    case (st)
      S_NORMAL: mode_status = C_NORM;
      S_HALT:   mode_status = C_HALT;
      S_STOP:   mode_status = C_STOP;
      default:  mode_status = C_SLOW;
    endcase

  // R12
  one_source_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !(osc_on && pll_on));

  // R4
  lock_before_sel_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $rose(sel_pll) |-> $past(lock_s[1]));

  // R5
  no_self_boost_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (st == S_SLOW && !(cmd_wr && cmd == C_NORM)) |=> st != S_GO_PLL);

  // R7
  halt_keeps_periph_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (st == S_HALT && !wake && !(wr_en && wr_sel)) |=> $stable(periph_clk_en));

  // R8
  stop_holds_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (mode_status == C_STOP && !wake) |=> mode_status == C_STOP);

  // R9
  halt_wake_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (st == S_HALT && wake) |=> cpu_clk_en);

endmodule

// File: tb/tb_clk_mode_ctrl.sv
`timescale 1ns/100ps
module tb_clk_mode_ctrl;
  localparam int NP = 8;

  logic osc_clk = 0, pll_clk = 0, rst_n = 0, pll_locked = 0;
  logic wr_en = 0, wr_sel = 0, wake = 0;
  logic [NP-1:0] wr_data = '0;
  logic cpu_clk_en, sys_clk;
  logic [1:0] mode_status;
  logic [NP-1:0] periph_clk_en;

  int checks = 0, errors = 0;
  logic exp_norm;
  logic [NP-1:0] exp_periph;

  always #4   osc_clk = ~osc_clk;
  always #2.7 pll_clk = ~pll_clk;

  clk_mode_ctrl #(.NPERIPH(NP)) dut (
    .osc_clk(osc_clk), .pll_clk(pll_clk), .rst_n(rst_n), .pll_locked(pll_locked),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .wake(wake),
    .cpu_clk_en(cpu_clk_en), .sys_clk(sys_clk), .mode_status(mode_status),
    .periph_clk_en(periph_clk_en));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge osc_clk);
    #1;
  endtask

  task automatic wr(input logic sel, input logic [NP-1:0] d);
    @(negedge osc_clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge osc_clk); wr_en = 0; #1;
  endtask

  task automatic pulse_wake();
    @(negedge osc_clk); wake = 1;
    @(negedge osc_clk); wake = 0; #1;
  endtask

  task automatic wait_status(input string req, input logic [1:0] code);
    int n = 0;
    while (mode_status !== code && n < 40) begin cyc(1); n++; end
    chk(req, mode_status, code);
  endtask

  // 1 = expect PLL edges on sys_clk, 0 = oscillator edges
  task automatic follow(input string req, input logic use_pll);
    int bad = 0;
    for (int i = 0; i < 3; i++) begin
      if (use_pll) @(posedge pll_clk); else @(posedge osc_clk);
      #0.5; if (sys_clk !== 1'b1) bad++;
      if (use_pll) @(negedge pll_clk); else @(negedge osc_clk);
      #0.5; if (sys_clk !== 1'b0) bad++;
    end
    chk(req, bad, 0);
  endtask

  task automatic stays_low(input string req);
    int bad = 0;
    for (int i = 0; i < 40; i++) begin #1.3; if (sys_clk !== 1'b0) bad++; end
    chk(req, bad, 0);
  endtask

  task automatic go_normal();
    wr(0, 8'h01);
    wait_status("R3", 2'b01);
    follow("R12", 1);
    exp_norm = 1;
  endtask

  task automatic go_slow();
    wr(0, 8'h00);
    chk("R6", mode_status, 2'b00);
    cyc(10);
    follow("R6", 0);
    exp_norm = 0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    exp_norm = 0;
    exp_periph = 8'hFE;
    cyc(3); rst_n = 1; cyc(2);
    chk("R1", mode_status, 2'b00);
    chk("R1", cpu_clk_en, 1);
    chk("R1", periph_clk_en, 8'hFE);
    follow("R2", 0);

    pll_locked = 1; cyc(30);
    chk("R5", mode_status, 2'b00);
    follow("R5", 0);

    pll_locked = 0;
    wr(0, 8'h01); cyc(30);
    chk("R4", mode_status, 2'b00);
    follow("R4", 0);
    pll_locked = 1;
    wait_status("R4", 2'b01);
    follow("R12", 1);
    follow("R3", 1);
    exp_norm = 1;

    wr(0, 8'h01); cyc(2);
    chk("R11", mode_status, 2'b01);

    wr(1, 8'h5A); exp_periph = 8'h5A;
    chk("R10", periph_clk_en, 8'h5A);

    wr(0, 8'h02);
    chk("R7", mode_status, 2'b10);
    chk("R7", cpu_clk_en, 0);
    chk("R7", periph_clk_en, 8'h5A);
    follow("R7", 1);
    wr(0, 8'h03); cyc(2);
    chk("R11", mode_status, 2'b10);
    pulse_wake();
    chk("R9", mode_status, 2'b01);
    chk("R9", cpu_clk_en, 1);

    wr(0, 8'h03);
    chk("R8", mode_status, 2'b11);
    chk("R8", cpu_clk_en, 0);
    chk("R8", periph_clk_en, 8'h00);
    cyc(10);
    stays_low("R8");
    wr(0, 8'h00); cyc(2);
    chk("R11", mode_status, 2'b11);
    pulse_wake();
    wait_status("R9", 2'b01);
    follow("R12", 1);
    chk("R9", periph_clk_en, 8'h5A);

    go_slow();

    wr(0, 8'h03);
    chk("R8", mode_status, 2'b11);
    cyc(10);
    stays_low("R8");
    pulse_wake();
    chk("R9", mode_status, 2'b00);
    cyc(10);
    follow("R9", 0);

    for (int it = 0; it < 40; it++) begin
      int op;
      op = int'($urandom % 4);
      case (op)
        0: begin
          logic [NP-1:0] d;
          d = NP'($urandom);
          wr(1, d); exp_periph = d;
          chk("R10", periph_clk_en, exp_periph);
        end
        1: begin
          wr(0, 8'h02);
          chk("R7", mode_status, 2'b10);
          cyc(int'($urandom % 5));
          pulse_wake();
          chk("R9", mode_status, {1'b0, exp_norm});
        end
        2: begin
          wr(0, 8'h03);
          chk("R8", periph_clk_en, 8'h00);
          cyc(4 + int'($urandom % 5));
          pulse_wake();
          wait_status("R9", {1'b0, exp_norm});
          cyc(10);
          follow("R9", exp_norm);
          chk("R9", periph_clk_en, exp_periph);
        end
        default: if (exp_norm) go_slow(); else go_normal();
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule